// File: doc/BRIEF.md
# Voltage-Controlled Period Generator

This block turns the signed output word of a digital voltage-loop compensator into the carrier period, counted in system clocks, that a ramp-based PWM uses for its next switching cycles. The control word first sets a switching frequency. The mapping starts at an upper frequency limit and falls linearly as the word rises, because the gain is negative. That frequency is clamped to an allowed window. The period count is then the integer reciprocal of the frequency, expressed in clock periods, and it is clamped to a minimum and a maximum count.

The reciprocal comes from a sequential restoring divider that produces one quotient bit per clock. A control sample that arrives while the divider is working is held in a single slot. A newer sample overwrites the held one, so only the most recent value is computed once the divider is free. The period output is registered and changes only in the cycle where the one-cycle ready flag is high. The defaults give a 60 MHz clock, a 40 kHz to 300 kHz window, a gain of 260 Hz per control LSB, and period limits of 200 and 1500 counts.

Top module: `vco_period_gen`

## Requirements
- R1: The frequency is computed as F = 300000 Hz - 260 Hz × W, where W is the control word read as two's complement. A larger word gives a lower frequency.
- R2: F is clamped to the range 40000 Hz through 300000 Hz before division. The divider is therefore never started with a divisor outside that window.
- R3: The unclamped period is floor(60000000 / F). This is the integer quotient of the clock rate divided by the clamped frequency.
- R4: The published period count always lies between 200 and 1500 inclusive. A quotient below 200 is replaced by 200, and a quotient above 1500 is replaced by 1500.
- R5: Suppose a sample is taken while the block is idle (calc_busy low). Its result appears with period_ready high exactly 27 clock cycles after the capturing edge. That is one cycle per quotient bit (26 bits) plus one output register.
- R6: While calc_busy is high, incoming samples are not started. The most recent one is kept, and any earlier held sample is discarded. The kept sample is started once the divider finishes. Each sample that is started yields exactly one ready pulse.
- R7: period_ready is a single-cycle pulse. period_cnt holds its value in every cycle where period_ready is low.
- R8: While reset is asserted, and after it is released, period_cnt reads 1500, and both period_ready and calc_busy read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_valid | input | 1 | Strobe marking a new control sample |
| ctrl_word | input | 16 | Signed compensator output |
| period_cnt | output | 11 | Carrier period in clock counts |
| period_ready | output | 1 | One-cycle pulse when period_cnt is updated |
| calc_busy | output | 1 | High while the reciprocal divider is running |

## Verification
The control words fall into three groups, and each group tells a different fault apart.

- **Interior words (1, 500, 700, 999).** These give fractional quotients. They expose rounding errors and a wrong gain sign or slope.
- **Zero, negative words and the two extreme codes.** These must land exactly on the frequency clamps, and so on the 200 and 1500 counts. A missing clamp or a sign-extension fault shows up here.
- **Samples sent during a running division.** An older sample is followed by a newer one, and the test checks that only the newer one produces a second result. It also counts ready pulses, to catch a dropped or duplicated computation.
- **Latency.** The delay to ready is counted on an idle start, which separates a correct step count from an off-by-one in the divider loop.

// File: rtl/vco_pkg.sv
package vco_pkg;

  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

  // Saturating select of a value into [lo, hi]
  function automatic longint sat_range(input longint v, input longint lo, input longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/vco_freq_map.sv
module vco_freq_map #(
  parameter int CTRL_W  = 16,
  parameter int FMAX_HZ = 300_000,
  parameter int FMIN_HZ = 40_000,
  parameter int GAIN_HZ = 260,
  localparam int FREQ_W = $clog2(FMAX_HZ + 1),
  localparam int CALC_W = CTRL_W + 34
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [FREQ_W-1:0] freq
);

  localparam logic signed [CALC_W-1:0] FMAX_S = CALC_W'(FMAX_HZ);
  localparam logic signed [CALC_W-1:0] FMIN_S = CALC_W'(FMIN_HZ);
  localparam logic signed [CALC_W-1:0] GAIN_S = CALC_W'(GAIN_HZ);

  logic signed [CALC_W-1:0] ctrl_ext;
  logic signed [CALC_W-1:0] prod;
  logic signed [CALC_W-1:0] f_raw;
  logic signed [CALC_W-1:0] f_sat;

  always_comb begin
    ctrl_ext = {{(CALC_W-CTRL_W){ctrl[CTRL_W-1]}}, ctrl};
    prod     = ctrl_ext * GAIN_S;
    f_raw    = FMAX_S - prod;
    if (f_raw < FMIN_S)      f_sat = FMIN_S;
    else if (f_raw > FMAX_S) f_sat = FMAX_S;
    else                     f_sat = f_raw;
    freq = f_sat[FREQ_W-1:0];
  end

endmodule

// File: rtl/vco_recip_div.sv
module vco_recip_div
  import vco_pkg::*;
#(
  parameter int NUM_W = 26,
  parameter int DEN_W = 19,
  localparam int CNT_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot
);

  div_state_e       state;
  logic [NUM_W-1:0] q_sh;
  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] dvs;
  logic [CNT_W-1:0] step;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem[DEN_W-1:0], q_sh[NUM_W-1]};
    diff  = trial - {1'b0, dvs};
    fits  = (trial >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DIV_IDLE;
      done  <= 1'b0;
      q_sh  <= '0;
      rem   <= '0;
      dvs   <= '0;
      step  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        DIV_IDLE: begin
          if (start) begin
            q_sh  <= num;
            rem   <= '0;
            dvs   <= den;
            step  <= '0;
            state <= DIV_RUN;
          end
        end
        default: begin
          q_sh <= {q_sh[NUM_W-2:0], fits};
          rem  <= fits ? diff : trial;
          step <= step + 1'b1;
          if (step == CNT_W'(NUM_W - 1)) begin
            state <= DIV_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state == DIV_RUN);
  assign quot = q_sh;

endmodule

// File: rtl/vco_period_clamp.sv
module vco_period_clamp #(
  parameter int NUM_W = 26,
  parameter int PMIN  = 200,
  parameter int PMAX  = 1500,
  localparam int PER_W = $clog2(PMAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [NUM_W-1:0] quot,
  output logic [PER_W-1:0] period,
  output logic             ready
);

  localparam logic [NUM_W-1:0] LO = NUM_W'(PMIN);
  localparam logic [NUM_W-1:0] HI = NUM_W'(PMAX);

  logic [NUM_W-1:0] q_sat;

  always_comb begin
    if (quot < LO)      q_sat = LO;
    else if (quot > HI) q_sat = HI;
    else                q_sat = quot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= PER_W'(PMAX);
      ready  <= 1'b0;
    end else begin
      ready <= done;
      if (done) period <= q_sat[PER_W-1:0];
    end
  end

endmodule

// File: rtl/vco_period_gen.sv
module vco_period_gen #(
  parameter int CTRL_W  = 16,
  parameter int CLK_HZ  = 60_000_000,
  parameter int FMAX_HZ = 300_000,
  parameter int FMIN_HZ = 40_000,
  parameter int GAIN_HZ = 260,
  parameter int PMIN    = 200,
  parameter int PMAX    = 1500,
  localparam int NUM_W  = $clog2(CLK_HZ + 1),
  localparam int FREQ_W = $clog2(FMAX_HZ + 1),
  localparam int PER_W  = $clog2(PMAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_valid,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic [PER_W-1:0]  period_cnt,
  output logic              period_ready,
  output logic              calc_busy
);

  logic              pend_vld;
  logic [CTRL_W-1:0] pend_word;
  logic [CTRL_W-1:0] src_word;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [FREQ_W-1:0] div_freq;
  logic [NUM_W-1:0]  div_quot;

  // Launch as soon as the divider is free; a fresh sample wins over a held one
  always_comb begin
    div_start = !div_busy && (ctrl_valid || pend_vld);
    src_word  = ctrl_valid ? ctrl_word : pend_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_word <= '0;
    end else if (div_start) begin
      pend_vld  <= 1'b0;
    end else if (ctrl_valid) begin
      pend_vld  <= 1'b1;
      pend_word <= ctrl_word;
    end
  end

  vco_freq_map #(
    .CTRL_W (CTRL_W),
    .FMAX_HZ(FMAX_HZ),
    .FMIN_HZ(FMIN_HZ),
    .GAIN_HZ(GAIN_HZ)
  ) u_map (
    .ctrl(src_word),
    .freq(div_freq)
  );

  vco_recip_div #(
    .NUM_W(NUM_W),
    .DEN_W(FREQ_W)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .start(div_start),
    .num  (NUM_W'(CLK_HZ)),
    .den  (div_freq),
    .busy (div_busy),
    .done (div_done),
    .quot (div_quot)
  );

  vco_period_clamp #(
    .NUM_W(NUM_W),
    .PMIN (PMIN),
    .PMAX (PMAX)
  ) u_clamp (
    .clk   (clk),
    .rst   (rst),
    .done  (div_done),
    .quot  (div_quot),
    .period(period_cnt),
    .ready (period_ready)
  );

  assign calc_busy = div_busy;

endmodule

// File: rtl/vco_period_gen_chk.sv
module vco_period_gen_chk #(
  parameter int FMAX_HZ = 300_000,
  parameter int FMIN_HZ = 40_000,
  parameter int PMIN    = 200,
  parameter int PMAX    = 1500,
  parameter int FREQ_W  = 19,
  parameter int PER_W   = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              div_start,
  input logic              div_busy,
  input logic              div_done,
  input logic [FREQ_W-1:0] div_freq,
  input logic [PER_W-1:0]  period_cnt,
  input logic              period_ready
);

  AST_FREQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    div_start |-> (div_freq >= FREQ_W'(FMIN_HZ) && div_freq <= FREQ_W'(FMAX_HZ))); // R2

  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
    period_ready |-> (period_cnt >= PER_W'(PMIN) && period_cnt <= PER_W'(PMAX))); // R4

  AST_READY_FROM_DIV: assert property (@(posedge clk) disable iff (rst)
    period_ready |-> $past(div_done)); // R5

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !div_start); // R6

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !period_ready |-> $stable(period_cnt)); // R7

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    period_ready |=> !period_ready); // R7

endmodule

bind vco_period_gen vco_period_gen_chk #(
  .FMAX_HZ(FMAX_HZ),
  .FMIN_HZ(FMIN_HZ),
  .PMIN   (PMIN),
  .PMAX   (PMAX),
  .FREQ_W (FREQ_W),
  .PER_W  (PER_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .div_start   (div_start),
  .div_busy    (div_busy),
  .div_done    (div_done),
  .div_freq    (div_freq),
  .period_cnt  (period_cnt),
  .period_ready(period_ready)
);

// File: tb/vco_period_gen_test.sv
module vco_period_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_valid = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [10:0] period_cnt;
  logic        period_ready;
  logic        calc_busy;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vco_period_gen uut (
    .clk         (clk),
    .rst         (rst),
    .ctrl_valid  (ctrl_valid),
    .ctrl_word   (ctrl_word),
    .period_cnt  (period_cnt),
    .period_ready(period_ready),
    .calc_busy   (calc_busy)
  );

  // Expected count from R1..R4
  function automatic int exp_period(input int w);
    longint f;
    longint p;
    f = 64'd300000 - 64'd260 * longint'(w);
    if (f < 40000) f = 40000;
    if (f > 300000) f = 300000;
    p = 64'd60000000 / f;
    if (p < 200) p = 200;
    if (p > 1500) p = 1500;
    return int'(p);
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int w);
    @(negedge clk);
    ctrl_valid = 1'b1;
    ctrl_word  = 16'(w);
    @(negedge clk);
    ctrl_valid = 1'b0;
  endtask

  // Waits for ready; returns negedges counted and flags any change without ready
  task automatic wait_ready(output int n, output bit moved);
    logic [10:0] prev;
    n = 0;
    moved = 1'b0;
    prev = period_cnt;
    while (!period_ready && n < 200) begin
      @(negedge clk);
      n++;
      if (!period_ready && period_cnt != prev) moved = 1'b1;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 period", period_cnt == 11'd1500, int'(period_cnt), 1500);
    check("R8 ready", period_ready == 1'b0, int'(period_ready), 0);
    check("R8 busy", calc_busy == 1'b0, int'(calc_busy), 0);
  endtask

  task automatic t_value(input int w, input string req);
    int n;
    bit moved;
    send(w);
    wait_ready(n, moved);
    check(req, period_cnt == 11'(exp_period(w)), int'(period_cnt), exp_period(w));
    check("R7 held without ready", !moved, int'(moved), 0);
    @(negedge clk);
    check("R7 single pulse", !period_ready, int'(period_ready), 0);
  endtask

  task automatic t_latency;
    int n;
    bit moved;
    send(700);
    check("R6 busy after start", calc_busy == 1'b1, int'(calc_busy), 1);
    wait_ready(n, moved);
    check("R5 latency", n == 27, n, 27);
    check("R3 value 700", period_cnt == 11'(exp_period(700)), int'(period_cnt), exp_period(700));
  endtask

  task automatic t_hold_busy;
    int n;
    int pulses;
    bit moved;
    send(0);
    repeat (4) @(negedge clk);
    send(500);
    repeat (3) @(negedge clk);
    send(700);
    wait_ready(n, moved);
    check("R6 first result", period_cnt == 11'd200, int'(period_cnt), 200);
    @(negedge clk);
    wait_ready(n, moved);
    check("R6 newest kept", period_cnt == 11'(exp_period(700)), int'(period_cnt), exp_period(700));
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (period_ready) pulses++;
    end
    check("R6 stale sample dropped", pulses == 0, pulses, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_value(0, "R3 word 0");
    t_value(500, "R1 word 500");
    t_value(999, "R1 word 999");
    t_value(1, "R3 word 1");
    t_value(1000, "R2 lower window edge");
    t_value(5000, "R2 below window");
    t_value(-100, "R2 above window");
    t_value(32767, "R4 max code");
    t_value(-32768, "R4 min code");
    t_latency();
    t_hold_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule